// File: doc/BRIEF.md
# Timer Clock Select, Prescaler and Counter

This block produces the count for a general-purpose timer. Everything runs on the system clock. A 2-bit source field picks the count source. One code stops counting. The other three codes pick the system clock itself, a slower fixed-rate clock, or an external clock. The two slower clocks are sampled through a two-flop synchronizer, and each rising edge found on them becomes a tick one system clock wide. Choosing the system clock gives a tick on every cycle.

Ticks feed a 7-bit prescaler counter. A 3-bit division code `div_code` sets the ratio to 2 to the power of that code, so the range runs from 1 to 128. The prescaler emits a step when its low `div_code` bits are all ones on a tick. Each step moves a 16-bit counter. The counter is bounded by a modulo value and runs in one of two modes: up, or up-then-down.

Top module: `timer_clk_prescaler`

## Requirements
- R1: After reset, `count` is 0 and `dir_down` is 0.
- R2: `src_sel` selects the tick source: 2'b00 gives no tick, 2'b01 the system clock, 2'b10 `fixed_clk_in` and 2'b11 `ext_clk_in`. With 2'b00, `count` and `dir_down` hold their values and are never cleared.
- R3: The counter advances once per 2^`div_code` ticks. With `div_code` = 1 it advances on every second tick.
- R4: When `updown` = 0, each step adds 1 to `count`. A step taken while `count` >= `mod_val` loads 0 instead.
- R5: When `updown` = 1, `count` goes from 0 up to `mod_val` and then back down to 0, and repeats. `dir_down` is 1 while the counter descends. It turns 1 on the step that leaves `mod_val` and turns 0 on the step that leaves 0. With `updown` = 0, `dir_down` is 0.
- R6: When source 2'b10 or 2'b11 is selected, each rising edge on the selected input moves the count by exactly one tick. The step reaches `count` on the third system clock edge after the input is sampled high.
- R7: A change of `div_code` or `src_sel` clears the prescaler and leaves `count` as it was. No tick is taken on the cycle of the change.
- R8: A step taken while `count` <= `mod_val` leaves `count` <= `mod_val`. With `mod_val` = 0 in up mode, `count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Tick source code (R2) |
| div_code | input | 3 | Division exponent, ratio is 2^div_code |
| updown | input | 1 | 0 for up counting, 1 for up-down counting |
| mod_val | input | 16 | Upper bound of the count |
| fixed_clk_in | input | 1 | Fixed-rate clock, asynchronous |
| ext_clk_in | input | 1 | External clock, asynchronous |
| count | output | 16 | Timer count |
| dir_down | output | 1 | 1 while counting down in up-down mode |
| cnt_step | output | 1 | Counter advances at the coming edge |

## Verification
The edge assertions assume that the fixed-rate and external inputs hold each level for at least two system clocks. A single-cycle pulse on them is not guaranteed to register as one tick. The bench therefore drives the external clock with 4-cycle halves and the fixed-rate clock with 3-cycle halves, which keeps both inside the stated rate limits. The bound assertion also assumes `mod_val` is stable around a step, so the bench changes `mod_val` only while reset is asserted.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 7;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             down;
  } cnt_state_t;

  // mask of the prescaler bits that must be all ones for a step
  function automatic logic [PRE_W-1:0] div_mask(input logic [CODE_W-1:0] code);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << code;
    return PRE_W'(one_hot - 1'b1);
  endfunction

  // counter state after one step
  function automatic cnt_state_t cnt_next(input cnt_state_t cur,
                                          input logic [CNT_W-1:0] lim,
                                          input logic ud);
    cnt_state_t n;
    n = cur;
    if (!ud) begin
      n.down = 1'b0;
      n.cnt  = (cur.cnt >= lim) ? '0 : cur.cnt + 1'b1;
    end else if (!cur.down) begin
      if (cur.cnt >= lim) begin
        n.down = 1'b1;
        n.cnt  = (cur.cnt == '0) ? '0 : cur.cnt - 1'b1;
      end else begin
        n.cnt = cur.cnt + 1'b1;
      end
    end else begin
      if (cur.cnt == '0) begin
        n.down = 1'b0;
        n.cnt  = (lim == '0) ? '0 : CNT_W'(1);
      end else begin
        n.cnt = cur.cnt - 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/tmr_tick_src.sv
`timescale 1ns/1ps
module tmr_tick_src #(
  parameter int SYNC_STAGES = 2,
  parameter int N_ASYNC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_sel,
  input  logic [N_ASYNC-1:0] async_in,   // [0] fixed, [1] external
  output logic [N_ASYNC-1:0] rise,
  output logic               tick
);
  import tmr_pkg::*;

  genvar gi;
  generate
    for (gi = 0; gi < N_ASYNC; gi++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      logic                   last_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain  <= '0;
          last_q <= 1'b0;
        end else begin
          chain  <= {chain[SYNC_STAGES-2:0], async_in[gi]};
          last_q <= chain[SYNC_STAGES-1];
        end
      end
      assign rise[gi] = chain[SYNC_STAGES-1] & ~last_q;

      a_r6_single_cycle_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise[gi] |=> !rise[gi]);
    end
  endgenerate

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_OFF:   tick = 1'b0;
      SRC_SYS:   tick = 1'b1;
      SRC_FIXED: tick = rise[0];
      SRC_EXT:   tick = rise[N_ASYNC-1];
      default:   tick = 1'b0;
    endcase
  end

  a_r2_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00) |-> !tick);
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W  = tmr_pkg::PRE_W,
  parameter int CODE_W = tmr_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] div_code,
  input  logic [1:0]        src_sel,
  output logic              cfg_change,
  output logic              step
);
  import tmr_pkg::*;

  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        sel_q;
  logic [PRE_W-1:0]  mask;

  assign mask       = div_mask(div_code);
  assign cfg_change = (div_code != code_q) || (src_sel != sel_q);
  assign step       = tick && !cfg_change && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      code_q <= '0;
      sel_q  <= '0;
    end else begin
      code_q <= div_code;
      sel_q  <= src_sel;
      if (cfg_change)  pre_q <= '0;
      else if (tick)   pre_q <= pre_q + 1'b1;
    end
  end

  a_r3_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick);
  a_r7_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (pre_q == '0));
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_change) |=> $stable(pre_q));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = tmr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             updown,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);
  import tmr_pkg::*;

  cnt_state_t cur, nxt;

  assign nxt      = cnt_next(cur, mod_val, updown);
  assign count    = cur.cnt;
  assign dir_down = cur.down;

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (step)    cur <= nxt;
    else if (!updown) cur.down <= 1'b0;
  end

  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
  a_r4_wrap_at_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !updown && count >= mod_val) |=> (count == '0));
  a_r8_stay_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count <= mod_val && $stable(mod_val)) |=> (count <= $past(mod_val)));
  a_r5_no_down_in_up_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !updown |=> !dir_down);
endmodule

// File: rtl/timer_clk_prescaler.sv
`timescale 1ns/1ps
module timer_clk_prescaler #(
  parameter int CNT_W  = tmr_pkg::CNT_W,
  parameter int PRE_W  = tmr_pkg::PRE_W,
  parameter int CODE_W = tmr_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              updown,
  input  logic [CNT_W-1:0]  mod_val,
  input  logic              fixed_clk_in,
  input  logic              ext_clk_in,
  output logic [CNT_W-1:0]  count,
  output logic              dir_down,
  output logic              cnt_step
);
  logic [1:0] rise;
  logic       tick;
  logic       cfg_change;

  tmr_tick_src #(.SYNC_STAGES(2), .N_ASYNC(2)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .async_in ({ext_clk_in, fixed_clk_in}),
    .rise     (rise),
    .tick     (tick)
  );

  tmr_prescaler #(.PRE_W(PRE_W), .CODE_W(CODE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .div_code   (div_code),
    .src_sel    (src_sel),
    .cfg_change (cfg_change),
    .step       (cnt_step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (cnt_step),
    .updown   (updown),
    .mod_val  (mod_val),
    .count    (count),
    .dir_down (dir_down)
  );

  a_r7_no_step_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |-> !cnt_step);
  a_r6_ext_step_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11 && cnt_step) |-> rise[1]);
endmodule

// File: tb/timer_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module timer_clk_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [2:0]  div_code = 3'd0;
  logic        updown = 1'b0;
  logic [15:0] mod_val = 16'd0;
  logic        fixed_clk_in = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic [15:0] count;
  logic        dir_down;
  logic        cnt_step;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  timer_clk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_code(div_code),
    .updown(updown), .mod_val(mod_val), .fixed_clk_in(fixed_clk_in),
    .ext_clk_in(ext_clk_in), .count(count), .dir_down(dir_down),
    .cnt_step(cnt_step)
  );

  // vector: div_code, updown, mod_val, cycles, expected count, expected dir
  localparam int NV = 10;
  localparam logic [52:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'd9,    16'd25,  16'd5,  1'b0},
    {3'd1, 1'b0, 16'd3,    16'd10,  16'd1,  1'b0},
    {3'd2, 1'b0, 16'd100,  16'd37,  16'd9,  1'b0},
    {3'd7, 1'b0, 16'd1000, 16'd300, 16'd2,  1'b0},
    {3'd0, 1'b1, 16'd3,    16'd4,   16'd2,  1'b1},
    {3'd0, 1'b1, 16'd3,    16'd3,   16'd3,  1'b0},
    {3'd0, 1'b1, 16'd3,    16'd6,   16'd0,  1'b1},
    {3'd1, 1'b1, 16'd5,    16'd23,  16'd1,  1'b0},
    {3'd0, 1'b0, 16'd0,    16'd7,   16'd0,  1'b0},
    {3'd3, 1'b1, 16'd4,    16'd100, 16'd4,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] dc, input logic ud, input logic [15:0] m);
    @(negedge clk);
    rst_n = 1'b0; src_sel = 2'b00; div_code = dc; updown = ud; mod_val = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input bit use_ext, input int half);
    if (use_ext) ext_clk_in = 1'b1; else fixed_clk_in = 1'b1;
    repeat (half) @(negedge clk);
    if (use_ext) ext_clk_in = 1'b0; else fixed_clk_in = 1'b0;
    repeat (half) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;

    // R1 reset state
    do_reset(3'd0, 1'b0, 16'd50);
    chk("R1 count", 32'(count), 0);
    chk("R1 dir_down", 32'(dir_down), 0);

    // vector table on the system clock source (R3 R4 R5 R8)
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][52:50], VEC[v][49], VEC[v][48:33]);
      src_sel = 2'b01;
      repeat (1 + int'(VEC[v][32:17])) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R3/R4/R5 vec%0d count", v), 32'(count), 32'(VEC[v][16:1]));
      chk($sformatf("R5 vec%0d dir_down", v), 32'(dir_down), 32'(VEC[v][0]));
    end

    // R2 freeze with source off, resume afterwards
    do_reset(3'd0, 1'b0, 16'd1000);
    src_sel = 2'b01;
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R2 running", 32'(count), 10);
    src_sel = 2'b00;
    repeat (20) @(negedge clk);
    chk("R2 frozen not cleared", 32'(count), 10);
    src_sel = 2'b01;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R2 resumed", 32'(count), 15);

    // R7 division change clears prescaler, keeps counter
    do_reset(3'd2, 1'b0, 16'd1000);
    src_sel = 2'b01;
    repeat (1 + 10) @(posedge clk);
    @(negedge clk);
    chk("R3 div4 before change", 32'(count), 2);
    div_code = 3'd3;
    @(posedge clk);
    @(negedge clk);
    chk("R7 count kept on change", 32'(count), 2);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R7 no step before 8 ticks", 32'(count), 2);
    @(posedge clk);
    @(negedge clk);
    chk("R7 step on 8th tick", 32'(count), 3);

    // R6 external clock edges
    do_reset(3'd0, 1'b0, 16'd1000);
    src_sel = 2'b11;
    repeat (3) @(negedge clk);
    ext_clk_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R6 ext no step before third edge", 32'(count), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 ext step at third edge", 32'(count), 1);
    repeat (4) @(negedge clk);
    ext_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) pulse(1'b1, 4);
    repeat (6) @(negedge clk);
    chk("R6 ext one tick per edge", 32'(count), 5);
    fixed_clk_in = 1'b1;
    repeat (8) @(negedge clk);
    fixed_clk_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 fixed input ignored on ext source", 32'(count), 5);

    // R6 fixed-rate clock edges with division 2
    do_reset(3'd1, 1'b0, 16'd1000);
    src_sel = 2'b10;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) pulse(1'b0, 3);
    repeat (6) @(negedge clk);
    chk("R6 fixed six edges div2", 32'(count), 3);

    // R2 edges ignored when off
    held = count;
    src_sel = 2'b00;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) pulse(1'b0, 3);
    repeat (6) @(negedge clk);
    chk("R2 off ignores edges", 32'(count), 32'(held));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule